// File: doc/BRIEF.md
# SAR Converter Serial Controller

This block is the digital half of a four-input, 16-bit successive-approximation converter with a synchronous serial port. A host lowers chip select and toggles a serial clock. On the rising edges it sends an 8-bit command: a start marker, a channel code, an input-mode flag and a two-bit power/clock mode. The block steers the analog multiplexer through decoded channel outputs. It opens the sample switch for the acquisition window and then drives a 16-bit trial word into the capacitor DAC. It makes one binary decision per step from an external comparator bit and returns the result MSB first on the falling edges.

All ports belong to one system clock domain. The serial clock and chip select are treated as slow synchronous inputs whose edges are detected in that domain. The host must keep the serial clock high and low for at least two system clocks each. Two conversion timings are available. In external timing the serial clock paces the bit decisions, and each decision appears on the output one falling edge after it is made. In internal timing the decisions are paced by the system clock divided by `INT_DIV`, and the result is read out later. Output-enable signals stand in for tri-state pins. An active-low shutdown input and the asynchronous reset both return every register to its idle value.

Top module: `sar_serial_ctrl`

## Requirements
- R1: While chip select is low and no command is in progress, rising serial-clock edges with din_i low are ignored. The first rising edge with din_i high is taken as bit 7 of a command, and the following seven bits come on the next seven rising edges.
- R2: Command bit 7 is the start marker. Bits 6..4 are the channel code, with the highest bit sent first. Bit 3 is ignored. Bit 2 is the input-mode flag, where 1 means single-ended. Bits 1..0 are the power/clock mode.
- R3: For channel codes 001, 101, 010 and 110, pos_ch_o is 0, 1, 2 and 3, and chan_sel_o shows the code. In single-ended mode neg_com_o is 1. In differential mode neg_com_o is 0 and neg_ch_o is 1, 0, 3 and 2 for those same codes.
- R4: hold_o goes low on the rising edge that delivers bit 4. It returns high on the rising edge that delivers bit 0, and it is high at all other times.
- R5: In external timing, busy_o rises on the falling edge that follows the last command bit and falls on the next falling edge.
- R6: In external timing, each of the next 16 falling edges puts one decision on dout_o, MSB first. A trial bit is kept when cmp_i is high and cleared otherwise, so the result is the largest code not above the input. After the 16 decisions, dout_o is 0 on later falling edges.
- R7: In internal timing, busy_o is low from the end of the command until 16 divided-clock decisions have been made, and then it goes high. The conversion continues even if chip select goes high. Each falling edge after that presents the next result bit, MSB first, followed by zeros.
- R8: Mode code 11 selects external timing and 10 selects internal timing. Codes 00 and 01 keep the current timing. A new timing applies from the conversion after the one whose command asked for it. Reset selects external timing.
- R9: When chip select is high, dout_oe_o is 0. busy_oe_o is 0 in external timing and 1 in internal timing. Raising chip select aborts a command in progress and an external-timing conversion.
- R10: A falling edge of chip select clears busy_o.
- R11: Reset or a low shdn_ni clears busy_o, dout_o and dac_code_o, sets hold_o high and restores external timing.
- R12: During an external-timing conversion, din_i is ignored until the LSB has been presented. High bits sent in that window start no new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shdn_ni | input | 1 | Shutdown, active low, clears all state |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock |
| din_i | input | 1 | Serial command data |
| cmp_i | input | 1 | Comparator result, 1 when the input is at or above the DAC level |
| dout_o | output | 1 | Serial result data |
| dout_oe_o | output | 1 | Drive enable for dout_o |
| busy_o | output | 1 | Busy flag |
| busy_oe_o | output | 1 | Drive enable for busy_o |
| chan_sel_o | output | 3 | Raw channel code |
| single_ended_o | output | 1 | Input-mode flag from the command |
| pos_ch_o | output | 2 | Channel routed to the positive input |
| neg_ch_o | output | 2 | Channel routed to the negative input in differential mode |
| neg_com_o | output | 1 | Negative input taken from the common pin |
| dac_code_o | output | DW | Trial code for the capacitor DAC |
| hold_o | output | 1 | Sample switch control, 0 while acquiring |

## Verification
The hardest state to reach is a timing change that is deferred by one conversion. A command that asks for internal timing must still produce an external-timing busy pulse. Only the command after it switches over, and a following keep-mode command must leave the internal timing in place. The stimulus reaches this by chaining commands across mode changes. It then checks the busy and output enables while chip select is high, and it repeats the chain after a shutdown pulse to confirm that shutdown restores external timing. The bench models the comparator as a compare of the DAC word against a programmed input value, so every conversion has a known expected code.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_EXT, ST_INT} core_st_e;

  // positive input index from channel code {a2,a1,a0}
  function automatic logic [1:0] chan_pos(input logic [2:0] c);
    return {c[1], c[2]};
  endfunction

  // differential partner of the positive input
  function automatic logic [1:0] chan_neg(input logic [2:0] c);
    return {c[1], ~c[2]};
  endfunction
endpackage

// File: rtl/sar_sclk_edge.sv
module sar_sclk_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  output logic rise_o,
  output logic fall_o,
  output logic cs_fall_o
);
  logic sclk_q, cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
    end
  end

  assign rise_o    = sclk_i & ~sclk_q & ~cs_ni;
  assign fall_o    = ~sclk_i & sclk_q & ~cs_ni;
  assign cs_fall_o = ~cs_ni & cs_q;
endmodule

// File: rtl/sar_cmd_rx.sv
module sar_cmd_rx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       kill_i,
  input  logic       abort_i,
  input  logic       en_i,
  input  logic       rise_i,
  input  logic       din_i,
  output logic       done_o,
  output logic [1:0] pwr_o,
  output logic [2:0] chan_o,
  output logic       single_o,
  output logic       acq_o
);
  localparam int CW = 8;
  localparam int NW = $clog2(CW);

  logic [NW-1:0] cnt_q;
  logic [1:0]    sh_q;
  logic [2:0]    chan_q;
  logic          single_q, acq_q;
  logic          take;

  assign take   = rise_i & en_i & ~abort_i & ~kill_i;
  assign done_o = take & (cnt_q == NW'(CW - 1));
  assign pwr_o  = {sh_q[0], din_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      chan_q   <= '0;
      single_q <= 1'b0;
      acq_q    <= 1'b0;
    end else if (kill_i) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      chan_q   <= '0;
      single_q <= 1'b0;
      acq_q    <= 1'b0;
    end else if (abort_i) begin
      cnt_q <= '0;
      acq_q <= 1'b0;
    end else if (take) begin
      if (cnt_q == '0) begin
        if (din_i) cnt_q <= NW'(1);  // start marker found
      end else begin
        sh_q  <= {sh_q[0], din_i};
        cnt_q <= cnt_q + NW'(1);
        if (cnt_q == NW'(3)) begin
          chan_q <= {sh_q, din_i};
          acq_q  <= 1'b1;
        end
        if (cnt_q == NW'(5)) single_q <= din_i;
        if (cnt_q == NW'(CW - 1)) acq_q <= 1'b0;
      end
    end
  end

  assign chan_o   = chan_q;
  assign single_o = single_q;
  assign acq_o    = acq_q;

  a_r4_acq_before_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> acq_q);
  a_r1_no_acq_while_hunting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> !acq_q);
endmodule

// File: rtl/sar_core.sv
module sar_core
  import sar_pkg::*;
#(
  parameter int DW      = 16,
  parameter int INT_DIV = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          kill_i,
  input  logic          cs_ni,
  input  logic          cs_fall_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          done_i,
  input  logic [1:0]    pwr_i,
  input  logic          cmp_i,
  output logic          busy_o,
  output logic          dout_o,
  output logic [DW-1:0] code_o,
  output logic          int_mode_o,
  output logic          rx_en_o
);
  localparam int IW = $clog2(DW);
  localparam int TW = (INT_DIV > 2) ? $clog2(INT_DIV) : 1;
  localparam logic [DW-1:0] MSB_ONE = {1'b1, {(DW-1){1'b0}}};

  core_st_e      st_q;
  logic          first_q, busy_q, dout_q, int_mode_q;
  logic [IW-1:0] idx_q;
  logic [TW-1:0] tick_q;
  logic [DW-1:0] code_q, sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; first_q <= 1'b0; busy_q <= 1'b0; dout_q <= 1'b0;
      int_mode_q <= 1'b0; idx_q <= '0; tick_q <= '0; code_q <= '0; sh_q <= '0;
    end else if (kill_i) begin
      st_q <= ST_IDLE; first_q <= 1'b0; busy_q <= 1'b0; dout_q <= 1'b0;
      int_mode_q <= 1'b0; idx_q <= '0; tick_q <= '0; code_q <= '0; sh_q <= '0;
    end else begin
      if (cs_fall_i) busy_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (fall_i) begin
            dout_q <= sh_q[DW-1];
            sh_q   <= {sh_q[DW-2:0], 1'b0};
          end
          if (done_i) begin
            // requested timing applies to the next conversion
            if (pwr_i == 2'b11) int_mode_q <= 1'b0;
            else if (pwr_i == 2'b10) int_mode_q <= 1'b1;
            idx_q <= IW'(DW - 1);
            if (int_mode_q) begin
              st_q   <= ST_INT;
              busy_q <= 1'b0;
              code_q <= MSB_ONE;
              tick_q <= '0;
            end else begin
              st_q    <= ST_EXT;
              first_q <= 1'b1;
              code_q  <= '0;
              sh_q    <= '0;
              dout_q  <= 1'b0;
            end
          end
        end
        ST_EXT: begin
          if (cs_ni) begin
            st_q   <= ST_IDLE;
            busy_q <= 1'b0;
          end else if (fall_i) begin
            if (first_q) begin
              busy_q         <= 1'b1;
              code_q[DW-1]   <= 1'b1;
              first_q        <= 1'b0;
            end else begin
              busy_q <= 1'b0;
              dout_q <= code_q[idx_q];
              if (idx_q == '0) st_q <= ST_IDLE;
              else begin
                idx_q                 <= idx_q - IW'(1);
                code_q[idx_q - IW'(1)] <= 1'b1;
              end
            end
          end else if (rise_i && !first_q) begin
            code_q[idx_q] <= cmp_i;
          end
        end
        ST_INT: begin
          if (tick_q == TW'(INT_DIV - 1)) begin
            tick_q        <= '0;
            code_q[idx_q] <= cmp_i;
            if (idx_q == '0) begin
              st_q   <= ST_IDLE;
              busy_q <= 1'b1;
              sh_q   <= {code_q[DW-1:1], cmp_i};
            end else begin
              idx_q                 <= idx_q - IW'(1);
              code_q[idx_q - IW'(1)] <= 1'b1;
            end
          end else begin
            tick_q <= tick_q + TW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = busy_q;
  assign dout_o     = dout_q;
  assign code_o     = code_q;
  assign int_mode_o = int_mode_q;
  assign rx_en_o    = (st_q == ST_IDLE);

  a_r5_busy_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EXT && $rose(busy_q)) |-> $past(fall_i));
  a_r6_low_bits_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> ((code_q & ((DW'(1) << idx_q) - DW'(1))) == '0));
  a_r7_int_busy_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_INT) |-> !busy_q);
  a_r8_mode_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_i && !kill_i) |=> $stable(int_mode_q));
  a_r9_cs_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && !done_i) |=> (st_q != ST_EXT));
  a_r11_kill_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> (st_q == ST_IDLE && !busy_q && code_q == '0 && !int_mode_q));
endmodule

// File: rtl/sar_serial_ctrl.sv
module sar_serial_ctrl
  import sar_pkg::*;
#(
  parameter int DW      = 16,
  parameter int INT_DIV = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shdn_ni,
  input  logic          cs_ni,
  input  logic          sclk_i,
  input  logic          din_i,
  input  logic          cmp_i,
  output logic          dout_o,
  output logic          dout_oe_o,
  output logic          busy_o,
  output logic          busy_oe_o,
  output logic [2:0]    chan_sel_o,
  output logic          single_ended_o,
  output logic [1:0]    pos_ch_o,
  output logic [1:0]    neg_ch_o,
  output logic          neg_com_o,
  output logic [DW-1:0] dac_code_o,
  output logic          hold_o
);
  logic rise, fall, cs_fall, done, rx_en, acq, single, int_mode, kill;
  logic [1:0] pwr;
  logic [2:0] chan;

  assign kill = ~shdn_ni;

  sar_sclk_edge u_edge (
    .clk_i, .rst_ni, .sclk_i, .cs_ni,
    .rise_o(rise), .fall_o(fall), .cs_fall_o(cs_fall)
  );

  sar_cmd_rx u_rx (
    .clk_i, .rst_ni, .kill_i(kill), .abort_i(cs_ni), .en_i(rx_en),
    .rise_i(rise), .din_i, .done_o(done), .pwr_o(pwr),
    .chan_o(chan), .single_o(single), .acq_o(acq)
  );

  sar_core #(.DW(DW), .INT_DIV(INT_DIV)) u_core (
    .clk_i, .rst_ni, .kill_i(kill), .cs_ni, .cs_fall_i(cs_fall),
    .rise_i(rise), .fall_i(fall), .done_i(done), .pwr_i(pwr), .cmp_i,
    .busy_o, .dout_o, .code_o(dac_code_o), .int_mode_o(int_mode), .rx_en_o(rx_en)
  );

  assign dout_oe_o      = ~cs_ni;
  assign busy_oe_o      = ~cs_ni | int_mode;
  assign chan_sel_o     = chan;
  assign single_ended_o = single;
  assign pos_ch_o       = chan_pos(chan);
  assign neg_ch_o       = chan_neg(chan);
  assign neg_com_o      = single;
  assign hold_o         = ~acq;
endmodule

// File: tb/sim_sar_serial_ctrl.sv
module sim_sar_serial_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, shdn_n = 1'b1, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [15:0] vin = '0;
  logic cmp, dout, dout_oe, busy, busy_oe, single, neg_com, hold;
  logic [2:0] chan;
  logic [1:0] pos, neg;
  logic [15:0] dac;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  assign cmp = (dac <= vin);

  sar_serial_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .shdn_ni(shdn_n), .cs_ni(cs_n), .sclk_i(sclk),
    .din_i(din), .cmp_i(cmp), .dout_o(dout), .dout_oe_o(dout_oe), .busy_o(busy),
    .busy_oe_o(busy_oe), .chan_sel_o(chan), .single_ended_o(single), .pos_ch_o(pos),
    .neg_ch_o(neg), .neg_com_o(neg_com), .dac_code_o(dac), .hold_o(hold)
  );

  // {command, input value}
  localparam logic [23:0] VEC [6] = '{
    {8'h97, 16'h0000}, {8'hD7, 16'hFFFF}, {8'hA3, 16'h8000},
    {8'hE3, 16'h7FFF}, {8'hD3, 16'h1234}, {8'h93, 16'hA5A5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sclk_cyc(input logic d);
    @(negedge clk); din = d; sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sclk_cyc(b[i]);
  endtask

  function automatic logic [1:0] exp_pos(input logic [2:0] a);
    case (a)
      3'b001: return 2'd0;
      3'b101: return 2'd1;
      3'b010: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [1:0] exp_neg(input logic [2:0] a);
    case (a)
      3'b001: return 2'd1;
      3'b101: return 2'd0;
      3'b010: return 2'd3;
      default: return 2'd2;
    endcase
  endfunction

  task automatic read16(output logic [15:0] got);
    for (int k = 15; k >= 0; k--) begin
      sclk_cyc(1'b0);
      got[k] = dout;
    end
  endtask

  task automatic run_ext(input logic [7:0] b, input logic [15:0] v, input int lead, input logic fill);
    logic [15:0] got;
    vin = v;
    for (int i = 0; i < lead; i++) sclk_cyc(1'b0);  // R1 leading zeros ignored
    for (int i = 7; i >= 0; i--) begin
      sclk_cyc(b[i]);
      if (i == 4) chk("R4 acquire", hold, 1'b0);
    end
    chk("R5 busy pulse", busy, 1'b1);
    chk("R4 hold", hold, 1'b1);
    chk("R2 chan", chan, b[6:4]);
    chk("R3 pos", pos, exp_pos(b[6:4]));
    if (b[2]) chk("R3 common", neg_com, 1'b1);
    else begin
      chk("R3 diff common", neg_com, 1'b0);
      chk("R3 neg", neg, exp_neg(b[6:4]));
    end
    for (int k = 15; k >= 0; k--) begin
      sclk_cyc(fill);
      got[k] = dout;
      if (k == 15) chk("R5 busy drop", busy, 1'b0);
    end
    chk("R6 result", got, v);
    sclk_cyc(1'b0);
    chk("R6 zero tail", dout, 1'b0);
    chk("R12 no restart", busy, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy, 1'b0);
    chk("R11 hold", hold, 1'b1);
    chk("R11 dac", dac, 16'h0);
    chk("R9 dout_oe", dout_oe, 1'b0);
    chk("R8 reset ext busy_oe", busy_oe, 1'b0);

    cs_n = 1'b0;
    for (int i = 0; i < 6; i++)
      run_ext(VEC[i][23:16], VEC[i][15:0], i % 3, 1'(i % 2));

    // R8 request internal: this conversion still external
    run_ext(8'h96, 16'h4321, 0, 1'b0);
    @(negedge clk); cs_n = 1'b1; repeat (2) @(negedge clk);
    chk("R9 busy_oe int", busy_oe, 1'b1);
    chk("R9 dout_oe off", dout_oe, 1'b0);
    @(negedge clk); cs_n = 1'b0; repeat (2) @(negedge clk);

    // R7 internal conversion, chip select raised mid-way
    vin = 16'h3C5A;
    send_byte(8'h94);
    chk("R7 busy low", busy, 1'b0);
    cs_n = 1'b1;
    repeat (100) @(negedge clk);
    chk("R7 busy done", busy, 1'b1);
    cs_n = 1'b0; repeat (2) @(negedge clk);
    chk("R10 cs fall clears", busy, 1'b0);
    read16(got);
    chk("R7 result", got, 16'h3C5A);
    sclk_cyc(1'b0);
    chk("R7 zero tail", dout, 1'b0);

    // R8 request external while internal: still internal
    vin = 16'h0F0F;
    send_byte(8'h97);
    chk("R8 deferred int", busy, 1'b0);
    repeat (100) @(negedge clk);
    chk("R7 busy done 2", busy, 1'b1);
    read16(got);
    chk("R7 result 2", got, 16'h0F0F);
    run_ext(8'h96, 16'hBEEF, 1, 1'b1);

    // R11 shutdown during internal timing
    vin = 16'h1111;
    send_byte(8'h96);
    repeat (100) @(negedge clk);
    chk("R7 busy done 3", busy, 1'b1);
    shdn_n = 1'b0; repeat (3) @(negedge clk); shdn_n = 1'b1;
    @(negedge clk);
    chk("R11 shdn busy", busy, 1'b0);
    chk("R11 shdn dac", dac, 16'h0);
    chk("R11 shdn hold", hold, 1'b1);
    cs_n = 1'b1; repeat (2) @(negedge clk);
    chk("R11 shdn ext mode", busy_oe, 1'b0);
    cs_n = 1'b0; repeat (2) @(negedge clk);
    run_ext(8'h95, 16'h2468, 0, 1'b0);  // R8 reserved code keeps external
    run_ext(8'h95, 16'hFFFE, 0, 1'b0);

    // R9 abort external conversion
    vin = 16'h5555;
    send_byte(8'h97);
    sclk_cyc(1'b0); sclk_cyc(1'b0);
    @(negedge clk); cs_n = 1'b1; repeat (2) @(negedge clk);
    chk("R9 abort dout_oe", dout_oe, 1'b0);
    chk("R9 abort busy_oe", busy_oe, 1'b0);
    chk("R9 abort busy", busy, 1'b0);
    cs_n = 1'b0; repeat (2) @(negedge clk);
    run_ext(8'hD3, 16'h5555, 2, 1'b0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule